// File: doc/BRIEF.md
# Saturating Lane Shifter with Precision Reduction

This block is a single-cycle shift unit for a packed-data datapath. One operation code selects the lane layout and the kind of shift. The layout is four byte lanes, two halfword lanes or one full word. The kinds of shift are:

- left shift, either wrapping or saturating;
- logical right shift;
- arithmetic right shift, with or without rounding;
- conversion of Q15 halfwords to unsigned bytes;
- extraction of a 32-bit window from a 64-bit accumulator.

Each accepted operation writes a registered result and a two-bit per-operation overflow code, one cycle after the operation is offered. The same overflow bits are ORed into a two-bit sticky flag register. Reset is the only way to clear the sticky flags.

Flag bit 0 is the shift/precision flag. Left shifts and Q15 reduction set it. Flag bit 1 is the extraction flag. Only accumulator extraction sets it.

Top module: `sat_shift_unit`

## Requirements
- R1: With `shamt_i` = 0, every shift opcode (0 to 9) returns `data_i` unchanged and raises no overflow.
- R2: Left-shift opcodes shift each lane left and keep the low lane bits. The opcodes are 0 (bytes), 1 (halfwords) and 3 (word). A lane overflows when its top s+1 input bits are not all equal to its sign bit. Overflow in any lane sets `ovf_o[0]`.
- R3: Saturating left shifts use opcode 2 (halfwords) and opcode 4 (word). They apply the R2 overflow rule. An overflowing lane is replaced by its most positive value (0x7FFF or 0x7FFFFFFF) when the input is non-negative, and by its most negative value (0x8000 or 0x80000000) when it is negative.
- R4: Opcode 5 shifts each byte lane right logically, filling with zeros. Opcode 6 shifts halfwords right with sign extension, and opcode 8 does the same for the word.
- R5: Rounding right shifts use opcode 7 (halfwords) and opcode 9 (word). For s > 0 the lane is shifted arithmetically by s-1, incremented by one, then shifted right by one more bit.
- R6: Opcode 10 reduces each Q15 halfword to a byte. Halfword lane k yields result byte k, and result bits 31:16 are zero. A negative lane gives 0x00 with overflow. A lane whose magnitude is above 0x7F80 gives 0xFF with overflow. Any other lane gives its bits 14:7.
- R7: Opcode 11 returns bits [s+31:s] of `acc_i`, where s is the 5-bit shift amount. It sets `ovf_o[1]` when bit 31 of that result differs from `acc_i[63]`, and it never sets `ovf_o[0]`. Opcodes other than 11 never set `ovf_o[1]`.
- R8: The shift amount is masked to the lane width. Byte lanes use `shamt_i[2:0]`, halfword lanes use `shamt_i[3:0]` and word operations use all five bits.
- R9: `res_o`, `ovf_o` and `sticky_o` change only in a cycle where `valid_i` is high. `sticky_o` accumulates the OR of every accepted `ovf_o` value and never clears except at reset.
- R10: While `rst_ni` is low, `res_o`, `ovf_o` and `sticky_o` are zero. This reset is asynchronous.
- R11: Opcodes 12 to 15 are unused. They produce a zero result and a zero overflow code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation offered this cycle |
| op_i | input | 4 | Operation code |
| data_i | input | 32 | Packed operand |
| shamt_i | input | 5 | Shift amount |
| acc_i | input | 64 | Accumulator contents for extraction |
| res_o | output | 32 | Registered result |
| ovf_o | output | 2 | Overflow code of the last accepted operation (bit 0 shift/precision, bit 1 extraction) |
| sticky_o | output | 2 | Sticky OR of all accepted overflow codes |

## Verification
A fault in a lane shifter shows up in `res_o` or `ovf_o[0]` one clock after the faulty operation is offered. Each lane can fail on its own, so every lane width is driven with patterns that overflow in a single lane and with patterns that overflow in none. The sticky register holds state across operations. A missing OR or a wrong clear is visible only at the first accepted operation that ought to leave a flag set. The bench therefore alternates overflowing and clean operations of both flag classes, and it checks that an idle cycle leaves all three outputs unchanged.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
   typedef enum logic [3:0] {
      OP_SHL_B   = 4'd0,
      OP_SHL_H   = 4'd1,
      OP_SHLS_H  = 4'd2,
      OP_SHL_W   = 4'd3,
      OP_SHLS_W  = 4'd4,
      OP_SHR_B   = 4'd5,
      OP_SRA_H   = 4'd6,
      OP_SRAR_H  = 4'd7,
      OP_SRA_W   = 4'd8,
      OP_SRAR_W  = 4'd9,
      OP_Q15_U8  = 4'd10,
      OP_ACC_EXT = 4'd11
   } ssu_op_e;

   localparam int FLG_SHIFT = 0;
   localparam int FLG_ACC   = 1;
endpackage

// File: rtl/ssu_lshift.sv
// One lane of left shift; overflow is judged on the top s+1 input bits.
module ssu_lshift #(
   parameter int W  = 8,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  a,
   input  logic [SW-1:0] s,
   input  logic          sat_en,
   output logic [W-1:0]  res,
   output logic          ovf
);
   localparam logic [SW-1:0] TOP_IDX = SW'(W - 1);

   logic [SW-1:0]       rev;
   logic signed [W-1:0] head;
   logic [W-1:0]        lim;

   assign rev  = TOP_IDX - s;
   assign head = $signed(a) >>> rev;
   assign ovf  = (head != {W{a[W-1]}});
   assign lim  = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
   assign res  = (sat_en && ovf) ? lim : (a << s);
endmodule

// File: rtl/ssu_rshift.sv
// One lane of right shift; ARITH picks sign fill or zero fill.
module ssu_rshift #(
   parameter int W     = 16,
   parameter bit ARITH = 1'b1,
   parameter int SW    = $clog2(W)
) (
   input  logic [W-1:0]  a,
   input  logic [SW-1:0] s,
   input  logic          rnd_en,
   output logic [W-1:0]  res
);
   logic                fill;
   logic signed [W:0]   ext;
   logic signed [W:0]   part;
   logic [SW-1:0]       sm1;

   generate
      if (ARITH) begin : g_arith
         assign fill = a[W-1];
      end else begin : g_logic
         assign fill = 1'b0;
      end
   endgenerate

   assign ext  = {fill, a};
   assign sm1  = s - SW'(1);
   assign part = ext >>> sm1;
   // part holds the lane shifted by s-1; bit 0 is the rounding bit
   assign res  = (s == '0) ? a : (part[W:1] + W'(part[0] & rnd_en));
endmodule

// File: rtl/ssu_q15_reduce.sv
// Clamp a Q15 halfword into an unsigned byte.
module ssu_q15_reduce (
   input  logic [15:0] h,
   output logic [7:0]  b,
   output logic        ovf
);
   logic big;

   assign big = (h[14:0] > 15'h7F80);
   assign ovf = h[15] | big;
   assign b   = h[15] ? 8'h00 : (big ? 8'hFF : h[14:7]);
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit #(
   parameter int DATA_W = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    valid_i,
   input  logic [3:0]              op_i,
   input  logic [DATA_W-1:0]       data_i,
   input  logic [$clog2(DATA_W)-1:0] shamt_i,
   input  logic [2*DATA_W-1:0]     acc_i,
   output logic [DATA_W-1:0]       res_o,
   output logic [1:0]              ovf_o,
   output logic [1:0]              sticky_o
);
   import ssu_pkg::*;

   localparam int NB    = DATA_W / 8;
   localparam int NH    = DATA_W / 16;
   localparam int SW    = $clog2(DATA_W);
   localparam int ACC_W = 2 * DATA_W;
   localparam int QPAD  = DATA_W - NH * 8;

   generate
      if ((DATA_W < 16) || (DATA_W % 16 != 0) || ((1 << SW) != DATA_W)) begin : g_bad_width
         $error("sat_shift_unit: DATA_W must be a power of two of at least 16");
      end
   endgenerate

   logic [DATA_W-1:0] b_shl, b_shr, h_shl, h_sra, w_shl, w_sra;
   logic [NB-1:0]     b_ovf;
   logic [NH-1:0]     h_ovf, q_ovf;
   logic [NH*8-1:0]   q_pack;
   logic              w_ovf;
   logic              h_sat, h_rnd, w_sat, w_rnd;

   assign h_sat = (op_i == OP_SHLS_H);
   assign h_rnd = (op_i == OP_SRAR_H);
   assign w_sat = (op_i == OP_SHLS_W);
   assign w_rnd = (op_i == OP_SRAR_W);

   // byte lanes: wrapping left shift and logical right shift
   for (genvar gb = 0; gb < NB; gb++) begin : g_byte
      ssu_lshift #(.W(8)) u_shl (
         .a(data_i[gb*8 +: 8]), .s(shamt_i[2:0]), .sat_en(1'b0),
         .res(b_shl[gb*8 +: 8]), .ovf(b_ovf[gb]));
      ssu_rshift #(.W(8), .ARITH(1'b0)) u_shr (
         .a(data_i[gb*8 +: 8]), .s(shamt_i[2:0]), .rnd_en(1'b0),
         .res(b_shr[gb*8 +: 8]));
   end

   // halfword lanes: left shift, arithmetic right shift, Q15 reduction
   for (genvar gh = 0; gh < NH; gh++) begin : g_half
      ssu_lshift #(.W(16)) u_shl (
         .a(data_i[gh*16 +: 16]), .s(shamt_i[3:0]), .sat_en(h_sat),
         .res(h_shl[gh*16 +: 16]), .ovf(h_ovf[gh]));
      ssu_rshift #(.W(16), .ARITH(1'b1)) u_sra (
         .a(data_i[gh*16 +: 16]), .s(shamt_i[3:0]), .rnd_en(h_rnd),
         .res(h_sra[gh*16 +: 16]));
      ssu_q15_reduce u_q15 (
         .h(data_i[gh*16 +: 16]), .b(q_pack[gh*8 +: 8]), .ovf(q_ovf[gh]));
   end

   // full word lane
   ssu_lshift #(.W(DATA_W)) u_w_shl (
      .a(data_i), .s(shamt_i), .sat_en(w_sat), .res(w_shl), .ovf(w_ovf));
   ssu_rshift #(.W(DATA_W), .ARITH(1'b1)) u_w_sra (
      .a(data_i), .s(shamt_i), .rnd_en(w_rnd), .res(w_sra));

   // accumulator window; shamt_i <= DATA_W-1 keeps it inside acc_i
   logic [DATA_W-1:0] x_res;
   logic              x_ovf;
   assign x_res = acc_i[shamt_i +: DATA_W];
   assign x_ovf = x_res[DATA_W-1] ^ acc_i[ACC_W-1];

   logic [DATA_W-1:0] nxt_res;
   logic [1:0]        nxt_ovf;

   always_comb begin
      nxt_res = '0;
      nxt_ovf = '0;
      case (op_i)
         OP_SHL_B: begin
            nxt_res = b_shl;
            nxt_ovf[FLG_SHIFT] = |b_ovf;
         end
         OP_SHL_H, OP_SHLS_H: begin
            nxt_res = h_shl;
            nxt_ovf[FLG_SHIFT] = |h_ovf;
         end
         OP_SHL_W, OP_SHLS_W: begin
            nxt_res = w_shl;
            nxt_ovf[FLG_SHIFT] = w_ovf;
         end
         OP_SHR_B:             nxt_res = b_shr;
         OP_SRA_H, OP_SRAR_H:  nxt_res = h_sra;
         OP_SRA_W, OP_SRAR_W:  nxt_res = w_sra;
         OP_Q15_U8: begin
            nxt_res = {{QPAD{1'b0}}, q_pack};
            nxt_ovf[FLG_SHIFT] = |q_ovf;
         end
         OP_ACC_EXT: begin
            nxt_res = x_res;
            nxt_ovf[FLG_ACC] = x_ovf;
         end
         default: begin
            nxt_res = '0;
            nxt_ovf = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o    <= '0;
         ovf_o    <= '0;
         sticky_o <= '0;
      end else if (valid_i) begin
         res_o    <= nxt_res;
         ovf_o    <= nxt_ovf;
         sticky_o <= sticky_o | nxt_ovf;
      end
   end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
   parameter int DATA_W = 32
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      valid_i,
   input logic [3:0]                op_i,
   input logic [DATA_W-1:0]         data_i,
   input logic [$clog2(DATA_W)-1:0] shamt_i,
   input logic [DATA_W-1:0]         res_o,
   input logic [1:0]                ovf_o,
   input logic [1:0]                sticky_o
);
   // R1: zero shift passes the operand and raises nothing
   p_zero_shift_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && shamt_i == '0 && op_i <= 4'd9) |=> (res_o == $past(data_i) && ovf_o == 2'b00));

   // R7: extraction flag belongs only to extraction
   p_acc_flag_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i != 4'd11) |=> !ovf_o[1]);

   // R7: extraction never raises the shift flag
   p_acc_no_shift_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == 4'd11) |=> !ovf_o[0]);

   // R6: negative low halfword clamps to zero with overflow
   p_q15_negative_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == 4'd10 && data_i[15]) |=> (res_o[7:0] == 8'h00 && ovf_o[0]));

   // R9: idle cycles leave every output unchanged
   p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(res_o) && $stable(ovf_o) && $stable(sticky_o)));

   // R9: a reported overflow is always reflected in the sticky flags
   p_sticky_covers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ovf_o & ~sticky_o) == 2'b00));

   // R9: sticky flags never clear outside reset
   p_sticky_no_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$fell(sticky_o[0]) && !$fell(sticky_o[1])));

   // R11: unused opcodes give zero
   p_unused_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i >= 4'd12) |=> (res_o == '0 && ovf_o == 2'b00));
endmodule

bind sat_shift_unit ssu_checker #(.DATA_W(DATA_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
   .data_i(data_i), .shamt_i(shamt_i), .res_o(res_o), .ovf_o(ovf_o),
   .sticky_o(sticky_o));

// File: tb/sat_shift_unit_tb_top.sv
`timescale 1ns/1ps
module sat_shift_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] data = '0;
   logic [4:0]  sh = '0;
   logic [63:0] acc = '0;
   logic [31:0] res;
   logic [1:0]  ovf;
   logic [1:0]  sticky;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sat_shift_unit #(.DATA_W(32)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .data_i(data),
      .shamt_i(sh), .acc_i(acc), .res_o(res), .ovf_o(ovf), .sticky_o(sticky));

   typedef struct packed {
      logic [3:0]  req;
      logic [3:0]  op;
      logic [31:0] data;
      logic [4:0]  sh;
      logic [63:0] acc;
      logic [31:0] res;
      logic [1:0]  ovf;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  4'd0,  32'h0140C0FF, 5'd1,  64'h0, 32'h028080FE, 2'b01}, // R2 byte lane overflow
      '{4'd8,  4'd0,  32'h10203040, 5'd9,  64'h0, 32'h20406080, 2'b01}, // R8 byte amount masked to 1
      '{4'd2,  4'd0,  32'h01020304, 5'd2,  64'h0, 32'h04080C10, 2'b00}, // R2 byte clean
      '{4'd2,  4'd1,  32'h1234FFFF, 5'd4,  64'h0, 32'h2340FFF0, 2'b01}, // R2 halfword wrap
      '{4'd3,  4'd2,  32'h1234FFFF, 5'd4,  64'h0, 32'h7FFFFFF0, 2'b01}, // R3 halfword positive clamp
      '{4'd3,  4'd2,  32'h80010100, 5'd3,  64'h0, 32'h80000800, 2'b01}, // R3 halfword negative clamp
      '{4'd2,  4'd3,  32'hC0000001, 5'd1,  64'h0, 32'h80000002, 2'b00}, // R2 word clean negative
      '{4'd2,  4'd3,  32'h40000001, 5'd1,  64'h0, 32'h80000002, 2'b01}, // R2 word overflow
      '{4'd3,  4'd4,  32'h40000001, 5'd1,  64'h0, 32'h7FFFFFFF, 2'b01}, // R3 word positive clamp
      '{4'd3,  4'd4,  32'h90000000, 5'd4,  64'h0, 32'h80000000, 2'b01}, // R3 word negative clamp
      '{4'd1,  4'd4,  32'h12345678, 5'd0,  64'h0, 32'h12345678, 2'b00}, // R1 zero shift
      '{4'd4,  4'd5,  32'h80FF7F01, 5'd3,  64'h0, 32'h101F0F00, 2'b00}, // R4 logical bytes
      '{4'd4,  4'd6,  32'h80007FFF, 5'd15, 64'h0, 32'hFFFF0000, 2'b00}, // R4 sign fill halfword
      '{4'd8,  4'd6,  32'h80000004, 5'd17, 64'h0, 32'hC0000002, 2'b00}, // R8 halfword amount masked to 1
      '{4'd5,  4'd7,  32'hFFFD0005, 5'd1,  64'h0, 32'hFFFF0003, 2'b00}, // R5 halfword rounding
      '{4'd5,  4'd7,  32'h7FFF8000, 5'd1,  64'h0, 32'h4000C000, 2'b00}, // R5 halfword extremes
      '{4'd4,  4'd8,  32'h80000010, 5'd4,  64'h0, 32'hF8000001, 2'b00}, // R4 word sign fill
      '{4'd5,  4'd9,  32'h00000017, 5'd2,  64'h0, 32'h00000006, 2'b00}, // R5 word round up
      '{4'd5,  4'd9,  32'hFFFFFFF9, 5'd2,  64'h0, 32'hFFFFFFFE, 2'b00}, // R5 word negative
      '{4'd6,  4'd10, 32'h40007F81, 5'd0,  64'h0, 32'h000080FF, 2'b01}, // R6 magnitude clamp
      '{4'd6,  4'd10, 32'h7F808000, 5'd0,  64'h0, 32'h0000FF00, 2'b01}, // R6 negative lane
      '{4'd6,  4'd10, 32'h01000080, 5'd0,  64'h0, 32'h00000201, 2'b00}, // R6 plain reduction
      '{4'd7,  4'd11, 32'h0, 5'd1,  64'h00000001_80000000, 32'hC0000000, 2'b10}, // R7 sign loss
      '{4'd7,  4'd11, 32'h0, 5'd4,  64'hFFFFFFFF_F0000000, 32'hFF000000, 2'b00}, // R7 negative kept
      '{4'd7,  4'd11, 32'h0, 5'd8,  64'h00000012_34567800, 32'h12345678, 2'b00}, // R7 window
      '{4'd7,  4'd11, 32'h0, 5'd0,  64'h80000000_00000000, 32'h00000000, 2'b10}, // R7 zero amount
      '{4'd11, 4'd13, 32'hFFFFFFFF, 5'd3, 64'h0, 32'h00000000, 2'b00}  // R11 unused opcode
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [3:0] o, input logic [31:0] d,
                        input logic [4:0] s, input logic [63:0] a);
      @(negedge clk);
      valid = v; op = o; data = d; sh = s; acc = a;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset res", 64'(res), 64'h0);
      check("R10 reset ovf", 64'(ovf), 64'h0);
      check("R10 reset sticky", 64'(sticky), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // sticky accumulation and valid gating
      apply(1'b1, 4'd3, 32'h1, 5'd1, 64'h0);
      check("R9 clean op sticky", 64'(sticky), 64'h0);
      apply(1'b1, 4'd3, 32'h40000000, 5'd1, 64'h0);
      check("R9 shift flag sticky", 64'(sticky), 64'h1);
      apply(1'b1, 4'd11, 32'h0, 5'd8, 64'h00000012_34567800);
      check("R9 clean extract ovf", 64'(ovf), 64'h0);
      check("R9 sticky kept", 64'(sticky), 64'h1);
      apply(1'b1, 4'd11, 32'h0, 5'd1, 64'h00000001_80000000);
      check("R9 both sticky", 64'(sticky), 64'h3);
      apply(1'b0, 4'd3, 32'h40000000, 5'd1, 64'h0);
      check("R9 idle res held", 64'(res), 64'hC0000000);
      check("R9 idle ovf held", 64'(ovf), 64'h2);
      check("R9 idle sticky held", 64'(sticky), 64'h3);

      // asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 async clear sticky", 64'(sticky), 64'h0);
      check("R10 async clear res", 64'(res), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(1'b1, VEC[i].op, VEC[i].data, VEC[i].sh, VEC[i].acc);
         check($sformatf("R%0d vec %0d res", VEC[i].req, i), 64'(res), 64'(VEC[i].res));
         check($sformatf("R%0d vec %0d ovf", VEC[i].req, i), 64'(ovf), 64'(VEC[i].ovf));
      end

      valid = 1'b0;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule